// File: doc/BRIEF.md
# Staged Shadow-Register Update Controller

This block holds the configuration registers of a video timing generator. Software loads them one word at a time over a three-wire serial port. Each register keeps two copies. The pending copy takes every write. The active copy drives the timing logic. Moving a value from the pending copy to the active copy is called a commit, and it happens only at a timing event chosen for that register. As a result, a field or line that is already running never sees a half-updated configuration.

Every register belongs to one of five commit groups:

- **Immediate:** the value takes effect as soon as the word arrives.
- **Frame:** commits on the falling edge of vertical sync. The commit can be pushed later to a programmed number of horizontal lines.
- **Field:** commits on the falling edge of vertical sync and never waits for the line delay.
- **Gate-line:** commits on the horizontal sync falling edge that closes the sensor-gate line.
- **Region:** commits on the region-start pulse of a region whose selected sequence uses that register.

Two further immediate control words configure the events. One sets the line delay. The other maps each of the four regions to a sequence index. Generating the actual patterns is outside this block.

In the default configuration there are eight bank registers at addresses 0 to 7:

| Address | Group | Sequence index |
|---|---|---|
| 0 | Immediate | — |
| 1 | Frame | — |
| 2 | Field | — |
| 3 | Gate-line | — |
| 4 to 7 | Region | 0 to 3 |

The line-delay word sits at 0x18 and the region map at 0x19.

Top module: `stg_shadow_ctrl`

## Requirements
- R1: A serial word is framed by `csn_i` low and sampled on `sck_i` rising edges, most significant bit first. It has 28 bits: bits 27..20 are the address and bits 19..0 are the data. A frame that ends with fewer than 28 edges writes nothing. Edges after the 28th in the same frame are ignored.
- R2: Address 0 is immediate. Its active value and its pending readback both equal the written data on the clock edge that samples the 28th bit. Its pending flag stays 0.
- R3: With the line delay set to 0, register 1 commits on the clock edge that first sees `vd_i` low after it was high.
- R4: The line delay is held in bits 7..0 of address 0x18 and applies when it is N > 0. Register 1 then commits on the Nth falling edge of `hd_i` after the vertical sync falling edge, and not before.
- R5: Register 2 commits on the vertical sync falling edge whatever the line delay is.
- R6: Register 3 commits on a falling edge of `hd_i` only while `sgline_i` is high. Falling edges of `hd_i` with `sgline_i` low leave it untouched.
- R7: Registers 4..7 carry sequence indices 0..3. Address 0x19 maps region r to a sequence in bits [2r+1:2r]. A pulse on `scp_i` with region `scp_rgn_i` = r commits only the register whose sequence index equals that field.
- R8: A write to a non-immediate register updates its pending readback and raises its pending flag. A commit copies the last value written and clears the flag.
- R9: A write that lands on the same clock edge as its register's commit event is held for the next commit. The commit on that edge applies the earlier pending value.
- R10: An active value never changes except at its own commit event. Writes to addresses outside the bank and the two control words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock, oversampled by `clk_i` |
| sdi_i | input | 1 | Serial data |
| csn_i | input | 1 | Serial frame select, active low |
| vd_i | input | 1 | Vertical sync level |
| hd_i | input | 1 | Horizontal sync level |
| sgline_i | input | 1 | High during the sensor-gate line |
| scp_i | input | 1 | Region-start pulse |
| scp_rgn_i | input | 2 | Number of the region starting |
| act_o | output | 160 | Active values, register i at bits [20i+19:20i] |
| pend_o | output | 160 | Pending values, same layout |
| pflag_o | output | 8 | Pending flag per register |

## Verification
The hardest case to reach is a serial word finishing on the very clock edge where a commit event for the same register fires (R9). To get there, the bench drops `vd_i` in the same half-cycle that raises the 28th serial clock. The delayed frame commit is the other deep state. For that, the bench sweeps the line delay from 1 to 4 and counts horizontal sync edges, checking every register after each edge.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
package stg_pkg;

    typedef enum logic [2:0] {
        CC_IMM,
        CC_VD,
        CC_FLD,
        CC_SG,
        CC_SCP
    } cclass_e;

    // Static commit-class assignment of bank index i.
    function automatic cclass_e class_of(int i);
        case (i)
            0:       return CC_IMM;
            1:       return CC_VD;
            2:       return CC_FLD;
            3:       return CC_SG;
            default: return CC_SCP;
        endcase
    endfunction

    // Sequence index referenced by a region-class register.
    function automatic int seq_of(int i, int nseq);
        return (i - 4) % nseq;
    endfunction

endpackage

// File: rtl/stg_serial_rx.sv
`timescale 1ns/1ps
module stg_serial_rx #(
    parameter int AW = 8,
    parameter int DW = 20
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic          csn_i,
    output logic          wr_vld_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o
);
    localparam int WL = AW + DW;
    localparam int CW = $clog2(WL + 1);

    typedef struct packed {
        logic          sck;
        logic [CW-1:0] cnt;
        logic [WL-2:0] sh;
    } st_t;

    st_t q, d;
    logic [WL-1:0] word;

    always_comb begin
        d        = q;
        d.sck    = sck_i;
        wr_vld_o = 1'b0;
        word     = {q.sh, sdi_i};
        if (csn_i) begin
            d.cnt = '0;
        end else if (sck_i && !q.sck && (q.cnt < CW'(WL))) begin
            d.sh  = word[WL-2:0];
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(WL - 1)) wr_vld_o = 1'b1;
        end
        wr_addr_o = word[WL-1 -: AW];
        wr_data_o = word[DW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/stg_event_gen.sv
`timescale 1ns/1ps
module stg_event_gen #(
    parameter int          AW       = 8,
    parameter int          DW       = 20,
    parameter int          NRGN     = 4,
    parameter int          SW       = 2,
    parameter int          LW       = 8,
    parameter logic [7:0]  DLY_ADDR = 8'h18,
    parameter logic [7:0]  MAP_ADDR = 8'h19
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_vld_i,
    input  logic [AW-1:0]            wr_addr_i,
    input  logic [DW-1:0]            wr_data_i,
    input  logic                     vd_i,
    input  logic                     hd_i,
    input  logic                     sgline_i,
    input  logic                     scp_i,
    input  logic [$clog2(NRGN)-1:0]  scp_rgn_i,
    output logic                     ev_vd_o,
    output logic                     ev_fld_o,
    output logic                     ev_sg_o,
    output logic [(1<<SW)-1:0]       ev_scp_o
);
    localparam int NSEQ = 1 << SW;
    localparam int MW   = NRGN * SW;

    typedef struct packed {
        logic          vd;
        logic          hd;
        logic          armed;
        logic [LW-1:0] cnt;
        logic [LW-1:0] dly;
        logic [MW-1:0] map;
    } st_t;

    st_t q, d;
    logic          vd_fall, hd_fall;
    logic [LW-1:0] nxt;
    logic [SW-1:0] sel;

    always_comb begin
        d        = q;
        d.vd     = vd_i;
        d.hd     = hd_i;
        vd_fall  = q.vd & ~vd_i;
        hd_fall  = q.hd & ~hd_i;
        nxt      = q.cnt + LW'(1);
        ev_fld_o = vd_fall;
        ev_sg_o  = hd_fall & sgline_i;
        ev_vd_o  = 1'b0;

        if (vd_fall) begin
            if (q.dly == '0) begin
                ev_vd_o = 1'b1;
                d.armed = 1'b0;
            end else begin
                d.armed = 1'b1;
                d.cnt   = '0;
            end
        end else if (q.armed && hd_fall) begin
            if (nxt == q.dly) begin
                ev_vd_o = 1'b1;
                d.armed = 1'b0;
            end else begin
                d.cnt = nxt;
            end
        end

        sel      = q.map[int'(scp_rgn_i) * SW +: SW];
        ev_scp_o = scp_i ? (NSEQ'(1) << sel) : '0;

        if (wr_vld_i && wr_addr_i == AW'(DLY_ADDR)) d.dly = wr_data_i[LW-1:0];
        if (wr_vld_i && wr_addr_i == AW'(MAP_ADDR)) d.map = wr_data_i[MW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/stg_shadow_bank.sv
`timescale 1ns/1ps
module stg_shadow_bank
    import stg_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 20,
    parameter int NREG = 8,
    parameter int SW   = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_vld_i,
    input  logic [AW-1:0]        wr_addr_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic                 ev_vd_i,
    input  logic                 ev_fld_i,
    input  logic                 ev_sg_i,
    input  logic [(1<<SW)-1:0]   ev_scp_i,
    output logic [NREG*DW-1:0]   act_o,
    output logic [NREG*DW-1:0]   pend_o,
    output logic [NREG-1:0]      pflag_o
);
    localparam int NSEQ = 1 << SW;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] act;
        logic [NREG-1:0][DW-1:0] pend;
        logic [NREG-1:0]         flag;
    } st_t;

    st_t  q, d;
    logic hit, commit;

    always_comb begin
        d      = q;
        hit    = 1'b0;
        commit = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            hit = wr_vld_i && (wr_addr_i == AW'(i));
            case (class_of(i))
                CC_VD:   commit = ev_vd_i;
                CC_FLD:  commit = ev_fld_i;
                CC_SG:   commit = ev_sg_i;
                CC_SCP:  commit = ev_scp_i[SW'(seq_of(i, NSEQ))];
                default: commit = 1'b0;
            endcase
            if (class_of(i) == CC_IMM) begin
                if (hit) begin
                    d.act[i]  = wr_data_i;
                    d.pend[i] = wr_data_i;
                end
            end else begin
                if (commit && q.flag[i]) begin
                    d.act[i]  = q.pend[i];
                    d.flag[i] = 1'b0;
                end
                if (hit) begin
                    d.pend[i] = wr_data_i;
                    d.flag[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign act_o   = q.act;
    assign pend_o  = q.pend;
    assign pflag_o = q.flag;
endmodule

// File: rtl/stg_shadow_ctrl.sv
`timescale 1ns/1ps
module stg_shadow_ctrl #(
    parameter int         AW       = 8,
    parameter int         DW       = 20,
    parameter int         NREG     = 8,
    parameter int         NRGN     = 4,
    parameter int         SW       = 2,
    parameter int         LW       = 8,
    parameter logic [7:0] DLY_ADDR = 8'h18,
    parameter logic [7:0] MAP_ADDR = 8'h19
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sck_i,
    input  logic                     sdi_i,
    input  logic                     csn_i,
    input  logic                     vd_i,
    input  logic                     hd_i,
    input  logic                     sgline_i,
    input  logic                     scp_i,
    input  logic [$clog2(NRGN)-1:0]  scp_rgn_i,
    output logic [NREG*DW-1:0]       act_o,
    output logic [NREG*DW-1:0]       pend_o,
    output logic [NREG-1:0]          pflag_o
);
    localparam int NSEQ = 1 << SW;

    logic            wr_vld;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic            ev_vd, ev_fld, ev_sg;
    logic [NSEQ-1:0] ev_scp;

    stg_serial_rx #(.AW(AW), .DW(DW)) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sck_i     (sck_i),
        .sdi_i     (sdi_i),
        .csn_i     (csn_i),
        .wr_vld_o  (wr_vld),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    stg_event_gen #(
        .AW(AW), .DW(DW), .NRGN(NRGN), .SW(SW), .LW(LW),
        .DLY_ADDR(DLY_ADDR), .MAP_ADDR(MAP_ADDR)
    ) u_ev (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_vld_i  (wr_vld),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .vd_i      (vd_i),
        .hd_i      (hd_i),
        .sgline_i  (sgline_i),
        .scp_i     (scp_i),
        .scp_rgn_i (scp_rgn_i),
        .ev_vd_o   (ev_vd),
        .ev_fld_o  (ev_fld),
        .ev_sg_o   (ev_sg),
        .ev_scp_o  (ev_scp)
    );

    stg_shadow_bank #(.AW(AW), .DW(DW), .NREG(NREG), .SW(SW)) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_vld_i  (wr_vld),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .ev_vd_i   (ev_vd),
        .ev_fld_i  (ev_fld),
        .ev_sg_i   (ev_sg),
        .ev_scp_i  (ev_scp),
        .act_o     (act_o),
        .pend_o    (pend_o),
        .pflag_o   (pflag_o)
    );
endmodule

// File: rtl/stg_shadow_chk.sv
`timescale 1ns/1ps
module stg_shadow_chk #(
    parameter int AW   = 8,
    parameter int DW   = 20,
    parameter int NREG = 8,
    parameter int SW   = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_vld,
    input logic [AW-1:0]        wr_addr,
    input logic [DW-1:0]        wr_data,
    input logic                 ev_vd,
    input logic                 ev_sg,
    input logic [(1<<SW)-1:0]   ev_scp,
    input logic [NREG*DW-1:0]   act,
    input logic [NREG-1:0]      pflag
);
    a_r2_imm_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_vld && wr_addr == AW'(0)) |=> act[0 +: DW] == $past(wr_data));

    a_r3_vd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ev_vd |=> $stable(act[1*DW +: DW]));

    a_r6_sg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ev_sg |=> $stable(act[3*DW +: DW]));

    a_r7_scp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ev_scp[0] |=> $stable(act[4*DW +: DW]));

    a_r7_scp_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ev_scp));

    a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_vld && wr_addr == AW'(1)) |=> pflag[1]);

    a_r8_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_vd && pflag[1] && !(wr_vld && wr_addr == AW'(1))) |=> !pflag[1]);
endmodule

bind stg_shadow_ctrl stg_shadow_chk #(.AW(AW), .DW(DW), .NREG(NREG), .SW(SW)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_vld  (wr_vld),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ev_vd   (ev_vd),
    .ev_sg   (ev_sg),
    .ev_scp  (ev_scp),
    .act     (act_o),
    .pflag   (pflag_o)
);

// File: tb/stg_shadow_ctrl_test.sv
`timescale 1ns/1ps
module stg_shadow_ctrl_test;
    localparam int NREG = 8;
    localparam int DW   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic vd = 1'b0, hd = 1'b0, sgl = 1'b0, scp = 1'b0;
    logic [1:0] rgn = 2'd0;
    logic [NREG*DW-1:0] act, pend;
    logic [NREG-1:0]    pflag;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] e_act  [NREG];
    logic [DW-1:0] e_pend [NREG];
    logic          e_flag [NREG];

    always #4 clk = ~clk;

    stg_shadow_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
        .vd_i(vd), .hd_i(hd), .sgline_i(sgl), .scp_i(scp), .scp_rgn_i(rgn),
        .act_o(act), .pend_o(pend), .pflag_o(pflag)
    );

    task automatic chk(string req, string what, int idx, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s reg%0d got=%h exp=%h", req, what, idx, got, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < NREG; i++) begin
            chk(req, "active", i, act[i*DW +: DW], e_act[i]);
            chk(req, "pending", i, pend[i*DW +: DW], e_pend[i]);
            chk(req, "flag", i, DW'(pflag[i]), DW'(e_flag[i]));
        end
    endtask

    function automatic void m_write(int i, logic [DW-1:0] v);
        e_pend[i] = v;
        if (i == 0) e_act[i] = v;
        else        e_flag[i] = 1'b1;
    endfunction

    function automatic void m_commit(int i);
        if (e_flag[i]) begin
            e_act[i]  = e_pend[i];
            e_flag[i] = 1'b0;
        end
    endfunction

    // nbits edges; if vd_drop, vd falls together with the 28th rising edge
    task automatic send(logic [7:0] a, logic [DW-1:0] v, int nbits, bit vd_drop);
        logic [27:0] w;
        w = {a, v};
        @(negedge clk) csn = 1'b0;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk) begin sck = 1'b0; sdi = (b < 28) ? w[27-b] : 1'b1; end
            @(negedge clk) begin sck = 1'b1; if (vd_drop && b == 27) vd = 1'b0; end
        end
        @(negedge clk) sck = 1'b0;
        @(negedge clk) csn = 1'b1;
        @(negedge clk);
    endtask

    task automatic vd_pulse();
        @(negedge clk) vd = 1'b1;
        @(negedge clk) vd = 1'b0;
        @(negedge clk);
    endtask

    task automatic hd_pulse(bit with_sg);
        @(negedge clk) begin hd = 1'b1; sgl = with_sg; end
        @(negedge clk) hd = 1'b0;
        @(negedge clk) sgl = 1'b0;
    endtask

    task automatic scp_pulse(logic [1:0] r);
        @(negedge clk) begin scp = 1'b1; rgn = r; end
        @(negedge clk) scp = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] seqmap [4];
        for (int i = 0; i < NREG; i++) begin
            e_act[i] = '0; e_pend[i] = '0; e_flag[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 reset");

        // R2 / R1: immediate register, several data patterns
        for (int k = 0; k < 3; k++) begin
            send(8'h00, DW'(20'hA5C3F + k * 20'h11111), 28, 1'b0);
            m_write(0, DW'(20'hA5C3F + k * 20'h11111));
            check_all("R2 immediate");
        end

        // R8: write every staged register, nothing becomes active
        for (int i = 1; i < NREG; i++) begin
            send(8'(i), DW'(i * 4099 + 17), 28, 1'b0);
            m_write(i, DW'(i * 4099 + 17));
        end
        check_all("R8 pending only");

        // R8: last write wins
        send(8'h01, 20'h0BEEF, 28, 1'b0); m_write(1, 20'h0BEEF);
        send(8'h01, 20'h0CAFE, 28, 1'b0); m_write(1, 20'h0CAFE);
        check_all("R8 last write");

        // R1: short frame dropped, extra edges ignored
        send(8'h02, 20'hFFFFF, 20, 1'b0);
        check_all("R1 short frame");
        send(8'h00, 20'h12345, 31, 1'b0); m_write(0, 20'h12345);
        check_all("R1 extra edges");

        // R10: unknown address changes nothing
        send(8'h10, 20'h77777, 28, 1'b0);
        check_all("R10 unknown address");

        // R6: hd without gate line does nothing, with it commits reg 3
        hd_pulse(1'b0);
        check_all("R6 hd without gate");
        hd_pulse(1'b1); m_commit(3);
        check_all("R6 gate line end");

        // R7: region map r0->2 r1->0 r2->3 r3->1
        seqmap[0] = 2'd2; seqmap[1] = 2'd0; seqmap[2] = 2'd3; seqmap[3] = 2'd1;
        send(8'h19, 20'h00072, 28, 1'b0);
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 4; s++) begin
                send(8'(4 + s), DW'(r * 256 + s * 16 + 5), 28, 1'b0);
                m_write(4 + s, DW'(r * 256 + s * 16 + 5));
            end
            scp_pulse(2'(r)); m_commit(4 + int'(seqmap[r]));
            check_all("R7 region commit");
        end

        // R3 / R5: no delay, both commit at vd fall
        vd_pulse(); m_commit(1); m_commit(2);
        check_all("R3 vd commit");

        // R4 / R5: delay sweep
        for (int dly = 1; dly <= 4; dly++) begin
            send(8'h18, DW'(dly), 28, 1'b0);
            send(8'h01, DW'(dly * 3001), 28, 1'b0); m_write(1, DW'(dly * 3001));
            send(8'h02, DW'(dly * 5003), 28, 1'b0); m_write(2, DW'(dly * 5003));
            vd_pulse(); m_commit(2);
            check_all("R5 field ignores delay");
            for (int h = 1; h <= dly; h++) begin
                hd_pulse(1'b0);
                if (h == dly) m_commit(1);
                check_all("R4 delayed commit");
            end
        end
        send(8'h18, 20'h00000, 28, 1'b0);

        // R9: write coincides with the commit edge
        send(8'h01, 20'h11111, 28, 1'b0); m_write(1, 20'h11111);
        @(negedge clk) vd = 1'b1;
        send(8'h01, 20'h22222, 28, 1'b1);
        m_commit(1); m_commit(2); m_write(1, 20'h22222);
        check_all("R9 write on commit edge");
        vd_pulse(); m_commit(1); m_commit(2);
        check_all("R9 next commit");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule